// File: doc/BRIEF.md
# Gated Time and Edge Counter Bank

This block keeps statistics for a trigger and flow-control system. Sixteen time counters accumulate clock cycles while a level is high: one per channel backpressure (XOFF) input, one for the combined XOFF level, and one that counts every clock as elapsed time. Sixteen edge counters count rising edges: one per pulse input, plus trigger candidates and accepted triggers. All counters are 64 bits wide.

The whole set of 32 counters is built four times, once for each gating context. Context 0 always counts. Context 1 counts while `run_i` is high. Context 2 counts while `spill_i` is high. Context 3 counts while both are high. Software reads any counter through a 16-bit register read port as four words. A read of the low word captures the upper 48 bits, so a later read of the other three words gives one coherent 64-bit value. A control register provides a one-shot clear of every counter and a freeze (lock) bit.

Top module: `gated_counter_bank`

## Requirements
- R1: Time counter k (k = 0..13) adds one on each clock edge where `xoff_ch_i[k]` is high. Counter 14 follows `xoff_all_i`. Counter 15 adds one on every clock edge.
- R2: Edge counter k (k = 0..13) adds one on each clock edge where `pulse_i[k]` is 1 and was 0 at the previous edge. Counters 14 and 15 do the same for `trig_cand_i` and `trig_acc_i`. Each counter adds at most one per clock. The previous-edge history is cleared to 0 by reset.
- R3: A counter in context c counts only when its gate is high: c=0 always, c=1 `run_i`, c=2 `spill_i`, c=3 `run_i & spill_i`. A context-3 counter never exceeds the matching counter in context 1 or context 2.
- R4: A read with `rd_en_i` high at a clock edge sets `rd_valid_o` and `rd_data_o` after that edge. With `rd_en_i` low, `rd_valid_o` is 0 after the edge. The counter address is 0x800 + c*0x80 + t*0x40 + k*4 + w, where t=0 selects time and t=1 selects edge, and w=0..3 selects the word, least significant first. A read returns the value the counter held before the edge. Both outputs are 0 after reset.
- R5: Writing address 0x040 with data bit 0 set zeroes every counter at that edge, even when the same edge would have counted. Bit 0 is not stored.
- R6: Data bit 1 of a write to 0x040 is stored as the lock. While the lock is 1, no counter changes, but the edge history keeps tracking its inputs. Reading 0x040 returns the lock in bit 1 and 0 in every other bit.
- R7: A read of word 0 returns counter bits 15:0 and captures bits 63:16. Reads of words 1..3 return bits 31:16, 47:32 and 63:48 of the last capture, whatever the counter has done since.
- R8: A read of any address that is neither 0x040 nor inside 0x800..0x9FF returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Run gate level |
| spill_i | input | 1 | Spill gate level |
| xoff_ch_i | input | 14 | Per-channel XOFF levels |
| xoff_all_i | input | 1 | Combined XOFF level |
| pulse_i | input | 14 | Pulse inputs for edge counting |
| trig_cand_i | input | 1 | Trigger candidate strobe |
| trig_acc_i | input | 1 | Accepted trigger strobe |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 12 | Register write address |
| wr_data_i | input | 16 | Register write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 12 | Register read address |
| rd_data_o | output | 16 | Read data, one cycle after the strobe |
| rd_valid_o | output | 1 | Read data valid |

## Verification
Assertions check these properties on every cycle:
- A clear leaves the counters at zero.
- A locked bank holds its counters still.
- An ungated context holds its counters still.
- Elapsed time steps by exactly one while counting.
- An edge counter never steps by more than one.
- An edge pulse lasts a single cycle.
- The word-0 capture changes only on a word-0 read.
- The context-3 elapsed count never exceeds the run-only or spill-only count.

The exact counts need the bench's reference model, which is fed the same random levels, pulses and gates. It is needed for:
- the mapping of each input to its counter slot and context;
- clear taking priority over counting;
- the edge history continuing to track inputs while locked;
- a low-word carry between the capture read and the later upper-word reads.

// File: rtl/gcb_pkg.sv
package gcb_pkg;
  localparam int unsigned GCB_N_CTX = 4;
  localparam int unsigned GCB_CNT_W = 64;
  localparam int unsigned GCB_REG_W = 16;
  localparam int unsigned GCB_ADDR_W = 12;

  typedef enum logic [1:0] {
    CTX_ALWAYS    = 2'd0,
    CTX_RUN       = 2'd1,
    CTX_SPILL     = 2'd2,
    CTX_RUN_SPILL = 2'd3
  } gcb_ctx_e;

  typedef enum logic {
    KIND_TIME = 1'b0,
    KIND_EDGE = 1'b1
  } gcb_kind_e;
endpackage

// File: rtl/gcb_edge_detect.sv
module gcb_edge_detect #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] in_i,
  output logic [W-1:0] edge_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= in_i;
  end

  assign edge_o = in_i & ~prev_q;

  for (genvar i = 0; i < W; i++) begin : g_chk
    assert_edge_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      edge_o[i] |=> !edge_o[i]);
  end
endmodule

// File: rtl/gcb_ctx_bank.sv
module gcb_ctx_bank #(
  parameter int unsigned N_CNT = 16,
  parameter int unsigned CNT_W = 64
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        gate_i,
  input  logic                        lock_i,
  input  logic                        clr_i,
  input  logic [N_CNT-1:0]            level_i,
  input  logic [N_CNT-1:0]            edge_i,
  output logic [N_CNT-1:0][CNT_W-1:0] time_o,
  output logic [N_CNT-1:0][CNT_W-1:0] edge_cnt_o
);
  logic [CNT_W-1:0] time_q [N_CNT];
  logic [CNT_W-1:0] edge_q [N_CNT];
  logic             cnt_en;

  assign cnt_en = gate_i && !lock_i;

  for (genvar k = 0; k < N_CNT; k++) begin : g_cnt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        time_q[k] <= '0;
        edge_q[k] <= '0;
      end else if (clr_i) begin  // clear wins over a same-cycle count
        time_q[k] <= '0;
        edge_q[k] <= '0;
      end else if (cnt_en) begin
        if (level_i[k]) time_q[k] <= time_q[k] + CNT_W'(1);
        if (edge_i[k])  edge_q[k] <= edge_q[k] + CNT_W'(1);
      end
    end
    assign time_o[k]     = time_q[k];
    assign edge_cnt_o[k] = edge_q[k];

    assert_edge_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clr_i |=> (edge_q[k] - $past(edge_q[k])) <= CNT_W'(1));
  end

  assert_clear_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (time_q[N_CNT-1] == '0) && (edge_q[N_CNT-1] == '0) && (time_q[0] == '0));

  assert_lock_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i && !clr_i) |=> $stable(time_q[N_CNT-1]) && $stable(edge_q[N_CNT-1]));

  assert_gate_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gate_i && !clr_i) |=> $stable(time_q[N_CNT-1]) && $stable(edge_q[0]));

  assert_elapsed_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en && !clr_i && level_i[N_CNT-1]) |=> time_q[N_CNT-1] == $past(time_q[N_CNT-1]) + CNT_W'(1));
endmodule

// File: rtl/gcb_read_port.sv
module gcb_read_port #(
  parameter int unsigned N_CTX     = 4,
  parameter int unsigned N_CNT     = 16,
  parameter int unsigned CNT_W     = 64,
  parameter int unsigned REG_W     = 16,
  parameter int unsigned ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'h040
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   rd_en_i,
  input  logic [ADDR_W-1:0]                      rd_addr_i,
  input  logic                                   lock_i,
  input  logic [N_CTX-1:0][N_CNT-1:0][CNT_W-1:0] time_i,
  input  logic [N_CTX-1:0][N_CNT-1:0][CNT_W-1:0] edge_i,
  output logic [REG_W-1:0]                       rd_data_o,
  output logic                                   rd_valid_o
);
  localparam int unsigned N_WORD = CNT_W / REG_W;
  localparam int unsigned WB     = $clog2(N_WORD);
  localparam int unsigned IB     = $clog2(N_CNT);
  localparam int unsigned CB     = $clog2(N_CTX);
  localparam int unsigned AB     = WB + IB + 1 + CB;
  localparam int unsigned SH_W   = CNT_W - REG_W;

  logic [WB-1:0]    word;
  logic [IB-1:0]    idx;
  logic             kind;
  logic [CB-1:0]    ctx;
  logic             hit_cnt;
  logic             hit_ctrl;
  logic             cap;
  logic [CNT_W-1:0] sel;
  logic [REG_W-1:0] hi_word;
  logic [SH_W-1:0]  shadow_q;

  assign word     = rd_addr_i[WB-1:0];
  assign idx      = rd_addr_i[WB+IB-1:WB];
  assign kind     = rd_addr_i[WB+IB];
  assign ctx      = rd_addr_i[AB-1:WB+IB+1];
  assign hit_cnt  = rd_addr_i[ADDR_W-1] && (rd_addr_i[ADDR_W-2:AB] == '0);
  assign hit_ctrl = (rd_addr_i == CTRL_ADDR);
  assign cap      = rd_en_i && hit_cnt && (word == '0);
  assign sel      = kind ? edge_i[ctx][idx] : time_i[ctx][idx];

  always_comb begin
    hi_word = '0;
    for (int w = 1; w < int'(N_WORD); w++)
      if (word == WB'(w)) hi_word = shadow_q[(w-1)*REG_W +: REG_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
      shadow_q   <= '0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) begin
        if (hit_cnt) begin
          if (word == '0) begin
            rd_data_o <= sel[REG_W-1:0];
            shadow_q  <= sel[CNT_W-1:REG_W];
          end else begin
            rd_data_o <= hi_word;
          end
        end else if (hit_ctrl) begin
          rd_data_o <= REG_W'({lock_i, 1'b0});
        end else begin
          rd_data_o <= '0;
        end
      end
    end
  end

  assert_rd_valid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o);
  assert_rd_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rd_valid_o);
  assert_shadow_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap |=> $stable(shadow_q));
  assert_unmapped_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !hit_cnt && !hit_ctrl) |=> rd_data_o == '0);
endmodule

// File: rtl/gated_counter_bank.sv
module gated_counter_bank
  import gcb_pkg::*;
#(
  parameter int unsigned N_CH   = 14,
  parameter int unsigned CNT_W  = GCB_CNT_W,
  parameter int unsigned REG_W  = GCB_REG_W,
  parameter int unsigned ADDR_W = GCB_ADDR_W,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'h040
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              spill_i,
  input  logic [N_CH-1:0]   xoff_ch_i,
  input  logic              xoff_all_i,
  input  logic [N_CH-1:0]   pulse_i,
  input  logic              trig_cand_i,
  input  logic              trig_acc_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [REG_W-1:0]  rd_data_o,
  output logic              rd_valid_o
);
  localparam int unsigned N_CNT = N_CH + 2;
  localparam int unsigned N_CTX = GCB_N_CTX;

  logic                                   ctrl_hit;
  logic                                   clr;
  logic                                   lock_q;
  logic [N_CNT-1:0]                       level;
  logic [N_CNT-1:0]                       edge_in;
  logic [N_CNT-1:0]                       edge_det;
  logic [N_CTX-1:0]                       gate;
  logic [N_CTX-1:0][N_CNT-1:0][CNT_W-1:0] time_all;
  logic [N_CTX-1:0][N_CNT-1:0][CNT_W-1:0] edge_all;

  assign ctrl_hit = wr_en_i && (wr_addr_i == CTRL_ADDR);
  assign clr      = ctrl_hit && wr_data_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       lock_q <= 1'b0;
    else if (ctrl_hit) lock_q <= wr_data_i[1];
  end

  assign level   = {1'b1, xoff_all_i, xoff_ch_i};
  assign edge_in = {trig_acc_i, trig_cand_i, pulse_i};

  assign gate[CTX_ALWAYS]    = 1'b1;
  assign gate[CTX_RUN]       = run_i;
  assign gate[CTX_SPILL]     = spill_i;
  assign gate[CTX_RUN_SPILL] = run_i && spill_i;

  gcb_edge_detect #(.W(N_CNT)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   (edge_in),
    .edge_o (edge_det)
  );

  for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
    gcb_ctx_bank #(.N_CNT(N_CNT), .CNT_W(CNT_W)) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .gate_i     (gate[c]),
      .lock_i     (lock_q),
      .clr_i      (clr),
      .level_i    (level),
      .edge_i     (edge_det),
      .time_o     (time_all[c]),
      .edge_cnt_o (edge_all[c])
    );
  end

  gcb_read_port #(
    .N_CTX(N_CTX), .N_CNT(N_CNT), .CNT_W(CNT_W), .REG_W(REG_W),
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)
  ) u_read (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_en_i    (rd_en_i),
    .rd_addr_i  (rd_addr_i),
    .lock_i     (lock_q),
    .time_i     (time_all),
    .edge_i     (edge_all),
    .rd_data_o  (rd_data_o),
    .rd_valid_o (rd_valid_o)
  );

  assert_ctx_order_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (time_all[CTX_RUN_SPILL][N_CNT-1] <= time_all[CTX_RUN][N_CNT-1]) &&
    (time_all[CTX_RUN_SPILL][N_CNT-1] <= time_all[CTX_SPILL][N_CNT-1]));
  assert_lock_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_hit |=> lock_q == $past(wr_data_i[1]));
endmodule

// File: tb/gated_counter_bank_tb.sv
module gated_counter_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0, spill = 1'b0;
  logic [13:0] xoff_ch = '0, pulse = '0;
  logic        xoff_all = 1'b0, cand = 1'b0, acc = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        rd_valid;

  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gated_counter_bank u_dut (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .spill_i(spill),
    .xoff_ch_i(xoff_ch), .xoff_all_i(xoff_all), .pulse_i(pulse),
    .trig_cand_i(cand), .trig_acc_i(acc),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid)
  );

  // reference model
  logic [63:0] m_time [4][16];
  logic [63:0] m_edge [4][16];
  logic [15:0] m_prev;
  logic        m_lock;
  logic [47:0] m_shadow;
  logic        exp_valid;
  logic [15:0] exp_data;
  string       exp_tag, cur_tag = "R4";

  function automatic logic [11:0] cnt_addr(int c, int t, int k, int w);
    return 12'h800 | 12'(c << 7) | 12'(t << 6) | 12'(k << 2) | 12'(w);
  endfunction

  function automatic logic gate_of(int c);
    case (c)
      0: return 1'b1;
      1: return run;
      2: return spill;
      default: return run & spill;
    endcase
  endfunction

  function automatic logic [15:0] lvl_vec();
    return {1'b1, xoff_all, xoff_ch};
  endfunction

  function automatic logic [15:0] edg_in();
    return {acc, cand, pulse};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 4; c++)
        for (int k = 0; k < 16; k++) begin m_time[c][k] = '0; m_edge[c][k] = '0; end
      m_prev = '0; m_lock = 0; m_shadow = '0; exp_valid = 0; exp_data = '0;
    end else begin
      logic [15:0] lv, ed;
      logic clr;
      exp_valid = rd_en;
      if (rd_en) begin
        exp_tag = cur_tag;
        if (rd_addr[11] && rd_addr[10:9] == 2'b00) begin
          logic [63:0] v;
          v = rd_addr[6] ? m_edge[rd_addr[8:7]][rd_addr[5:2]] : m_time[rd_addr[8:7]][rd_addr[5:2]];
          if (rd_addr[1:0] == 2'd0) begin exp_data = v[15:0]; m_shadow = v[63:16]; end
          else exp_data = m_shadow[(int'(rd_addr[1:0])-1)*16 +: 16];
          if (rd_addr[1:0] != 2'd0) exp_tag = "R7";
        end else if (rd_addr == 12'h040) begin
          exp_data = {14'd0, m_lock, 1'b0}; exp_tag = "R6";
        end else begin
          exp_data = '0; exp_tag = "R8";
        end
      end
      lv = lvl_vec();
      ed = edg_in() & ~m_prev;
      clr = wr_en && wr_addr == 12'h040 && wr_data[0];
      for (int c = 0; c < 4; c++)
        for (int k = 0; k < 16; k++) begin
          if (clr) begin m_time[c][k] = '0; m_edge[c][k] = '0; end
          else if (!m_lock && gate_of(c)) begin
            if (lv[k]) m_time[c][k] += 64'd1;
            if (ed[k]) m_edge[c][k] += 64'd1;
          end
        end
      m_prev = edg_in();
      if (wr_en && wr_addr == 12'h040) m_lock = wr_data[1];
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rd_valid !== exp_valid) begin
        total++; bad++;
        $display("FAIL R4 rd_valid actual=%0b expected=%0b", rd_valid, exp_valid);
      end else if (exp_valid) begin
        total++;
        if (rd_data !== exp_data) begin
          bad++;
          $display("FAIL %s addr=%h actual=%h expected=%h", exp_tag, $past(rd_addr), rd_data, exp_data);
        end
      end
    end
  end

  task automatic idle_inputs();
    rd_en = 0; wr_en = 0;
  endtask

  task automatic rand_inputs(int p_run, int p_spill);
    xoff_ch  = 14'($urandom);
    xoff_all = $urandom_range(0, 1) == 1;
    pulse    = 14'($urandom) & 14'($urandom);
    cand     = $urandom_range(0, 2) == 0;
    acc      = $urandom_range(0, 3) == 0;
    run      = $urandom_range(0, 99) < p_run;
    spill    = $urandom_range(0, 99) < p_spill;
  endtask

  task automatic write_ctrl(logic [15:0] d);
    @(negedge clk); rd_en = 0; wr_en = 1; wr_addr = 12'h040; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [11:0] a);
    @(negedge clk); wr_en = 0; rd_en = 1; rd_addr = a;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic random_phase(string tag, int cycles, int kind);
    cur_tag = tag;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      rand_inputs(60, 50);
      rd_en = $urandom_range(0, 1) == 1;
      rd_addr = cnt_addr($urandom_range(0, 3),
                         kind < 0 ? $urandom_range(0, 1) : kind,
                         $urandom_range(0, 15), $urandom_range(0, 3));
    end
    @(negedge clk); rd_en = 0;
  endtask

  task automatic read_all_locked(string tag);
    cur_tag = tag;
    for (int c = 0; c < 4; c++)
      for (int t = 0; t < 2; t++)
        for (int k = 0; k < 16; k++)
          for (int w = 0; w < 4; w++) rd(cnt_addr(c, t, k, w));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    total++;
    if (rd_valid !== 1'b0 || rd_data !== 16'h0) begin
      bad++; $display("FAIL R4 reset outputs actual=%b/%h expected=0/0000", rd_valid, rd_data);
    end
    rst_n = 1;
    // R1 time counters under random levels
    random_phase("R1", 1500, 0);
    // R2 edge counters under random pulses
    random_phase("R2", 1500, 1);
    // R3 gating contexts with biased gates
    cur_tag = "R3";
    for (int i = 0; i < 800; i++) begin
      @(negedge clk); rand_inputs(i < 400 ? 90 : 10, i < 400 ? 20 : 85);
      rd_en = $urandom_range(0, 2) == 0;
      rd_addr = cnt_addr($urandom_range(0, 3), $urandom_range(0, 1), $urandom_range(0, 15), 0);
    end
    @(negedge clk); rd_en = 0;
    // R6 lock: inputs keep moving, counters frozen, edge history tracked
    write_ctrl(16'h0002);
    rd(12'h040);
    for (int i = 0; i < 50; i++) begin @(negedge clk); rand_inputs(50, 50); end
    read_all_locked("R6");
    pulse = '1; cand = 1; acc = 1;
    write_ctrl(16'h0000);  // unlock with inputs already high: no new edge
    repeat (5) @(negedge clk);
    rd(12'h040);
    cur_tag = "R6"; rd(cnt_addr(0, 1, 14, 0)); rd(cnt_addr(0, 1, 3, 0));
    // R5 clear while every input is active
    run = 1; spill = 1; xoff_ch = '1; xoff_all = 1; pulse = '0; cand = 0; acc = 0;
    @(negedge clk); pulse = '1; cand = 1; acc = 1;
    wr_en = 1; wr_addr = 12'h040; wr_data = 16'h0001;
    @(negedge clk); wr_en = 0;
    cur_tag = "R5";
    rd(cnt_addr(3, 1, 15, 0)); rd(cnt_addr(3, 0, 15, 0)); rd(cnt_addr(0, 0, 14, 0));
    write_ctrl(16'h0003);  // clear and lock together
    read_all_locked("R5");
    rd(12'h040);
    // R8 unmapped addresses
    cur_tag = "R8";
    rd(12'h000); rd(12'h041); rd(12'h600); rd(12'hA04); rd(12'hE00); rd(12'h7FF);
    // R7 coherence across a low-word carry
    write_ctrl(16'h0001);
    run = 0; spill = 0; xoff_ch = '0; xoff_all = 0; pulse = '0; cand = 0; acc = 0;
    repeat (65530) @(negedge clk);
    cur_tag = "R7";
    for (int i = 0; i < 12; i++) begin
      rd(cnt_addr(0, 0, 15, 0)); rd(cnt_addr(0, 0, 15, 1));
      repeat (3) @(negedge clk);
      rd(cnt_addr(0, 0, 15, 2)); rd(cnt_addr(0, 0, 15, 3)); rd(cnt_addr(0, 0, 15, 1));
    end
    random_phase("R4", 600, -1);
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule